// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This controller shifts the phase of a PLL output clock in single-tap steps, each tap being one eighth of the VCO period, without going through the serial reconfiguration chain. A requester presents a target counter code, a direction and a step count in one cycle. The block then issues one step-enable pulse per step on the free-running scan clock, and waits for the PLL's completion line to fall and rise again before it issues the next pulse. The output clocks keep running while the steps are applied.

The counter-select and direction outputs are registered on the scan clock, so the PLL samples them on a rising edge. They stay fixed for the whole sequence. When the last step has completed, the block reports done for one cycle. It reports an error for one cycle if the requested code is reserved, or if the PLL fails to answer within a programmable number of scan-clock cycles. After an error the sequence is dropped and the block returns to idle.

Top module: `phstep_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes idle and drives sel_code, dir_up, step_en, busy, done and err low.
- R2: The accepted code is driven on sel_code: 000 selects every output counter, 001 the feedback counter, and 010 to 110 the output counters 0 to 4. dir_up is driven 1 for a later phase and 0 for an earlier one. Both are valid at least one cycle before step_en rises and stay unchanged while busy is high.
- R3: A request with code 111 raises err for the following cycle. It issues no step_en pulse and leaves busy low.
- R4: Each step holds step_en high for exactly PULSE_CYC consecutive cycles (2 by default).
- R5: The next step_en pulse rises only after pll_done has been seen low and then high again following the previous pulse.
- R6: A request for N steps (N from 1 to 255) gives exactly N pulses. done goes high for one cycle, in the cycle after the final completion is seen, and busy is low in that cycle.
- R7: A request with a step count of zero raises done in the following cycle, with no pulse and with busy staying low.
- R8: If pll_done has not completed its low-then-high return by the time the cycle counter reaches tmo_limit, the sequence is aborted. err rises tmo_limit+1 cycles after step_en rose, and in that cycle step_en, sel_code, dir_up and busy are low.
- R9: Requests presented while busy is high are ignored. The running sequence keeps its code, its direction and its step count.
- R10: busy is high from the cycle after a request is accepted until the cycle in which done or err is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_target | input | 3 | Counter code of the request |
| req_up | input | 1 | Requested direction, 1 = later |
| req_steps | input | CNT_W | Number of single-tap steps |
| tmo_limit | input | TMO_W | Completion timeout in clock cycles |
| pll_done | input | 1 | Completion handshake from the PLL |
| sel_code | output | 3 | Counter select driven to the PLL |
| dir_up | output | 1 | Direction driven to the PLL |
| step_en | output | 1 | Step-enable pulse to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion flag |
| err | output | 1 | One-cycle error flag |

## Verification
The assertions check several properties on every cycle: that select and direction do not move while busy, that the reserved code never goes out with a pulse, that each pulse lasts exactly its programmed width, that done and err stay single-cycle and never coincide, and that step_en stays quiet while idle. Some behaviour depends on the handshake history and can only be shown by the bench's scenarios with a behavioural PLL stand-in at several latencies. These are the exact number of pulses per request, the gating of each pulse on a full low-then-high completion, the timeout latency, the zero-count and reserved-code shortcuts, and the dropping of requests that arrive during a run.

// File: rtl/phstep_pkg.sv
package phstep_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_PULSE = 2'd2,
      ST_WAIT  = 2'd3
   } phs_state_t;

   localparam int unsigned SEL_W = 3;
   localparam logic [SEL_W-1:0] SEL_RSVD = 3'b111;

endpackage

// File: rtl/phstep_tally.sv
module phstep_tally #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] goal,
   output logic             last
);
   localparam int unsigned EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] nxt;

   assign nxt  = {1'b0, cnt_q} + EXT_W'(1);
   assign last = (nxt == {1'b0, goal});

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (inc)      cnt_q <= nxt[CNT_W-1:0];
   end

   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (cnt_q != '1));
endmodule

// File: rtl/phstep_guard.sv
module phstep_guard #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;

   assign expired = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)           cnt_q <= '0;
      else if (run && cnt_q != '1) cnt_q <= cnt_q + TMO_W'(1);
   end
endmodule

// File: rtl/phstep_pwidth.sv
module phstep_pwidth #(
   parameter int unsigned PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int unsigned PW_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   generate
      if (PULSE_CYC < 1) begin : g_bad_width
         $error("PULSE_CYC must be at least 1");
      end
      if (PULSE_CYC == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_multi
         logic [PW_W-1:0] cnt_q;
         assign last = (cnt_q == PW_W'(PULSE_CYC - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt_q <= '0;
            else if (!last)     cnt_q <= cnt_q + PW_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/phstep_seq.sv
module phstep_seq
   import phstep_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TMO_W     = 16,
   parameter int unsigned PULSE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_target,
   input  logic             req_up,
   input  logic [CNT_W-1:0] req_steps,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             pll_done,
   output logic [2:0]       sel_code,
   output logic             dir_up,
   output logic             step_en,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("TMO_W too small");
      end
   endgenerate

   phs_state_t       st_q;
   logic [2:0]       sel_q;
   logic             dir_q, en_q, done_q, err_q, lowseen_q;
   logic [CNT_W-1:0] goal_q;
   logic             tmo_hit, pw_last, tally_last, step_ok;

   assign step_ok = (st_q == ST_WAIT) && lowseen_q && pll_done;

   phstep_tally #(.CNT_W(CNT_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .clr(st_q == ST_IDLE), .inc(step_ok),
      .goal(goal_q), .last(tally_last));

   phstep_guard #(.TMO_W(TMO_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .clr(st_q == ST_SETUP),
      .run(st_q == ST_PULSE || st_q == ST_WAIT),
      .limit(tmo_limit), .expired(tmo_hit));

   phstep_pwidth #(.PULSE_CYC(PULSE_CYC)) u_pw (
      .clk(clk), .rst_n(rst_n), .run(st_q == ST_PULSE), .last(pw_last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         sel_q     <= '0;
         dir_q     <= 1'b0;
         en_q      <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         lowseen_q <= 1'b0;
         goal_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               if (req_target == SEL_RSVD)  err_q  <= 1'b1;
               else if (req_steps == '0)    done_q <= 1'b1;
               else begin
                  st_q   <= ST_SETUP;
                  sel_q  <= req_target;
                  dir_q  <= req_up;
                  goal_q <= req_steps;
               end
            end
            ST_SETUP: begin
               st_q      <= ST_PULSE;
               en_q      <= 1'b1;
               lowseen_q <= 1'b0;
            end
            ST_PULSE: begin
               if (!pll_done) lowseen_q <= 1'b1;
               if (tmo_hit) begin
                  st_q <= ST_IDLE; en_q <= 1'b0; sel_q <= '0; dir_q <= 1'b0;
                  err_q <= 1'b1;
               end else if (pw_last) begin
                  en_q <= 1'b0;
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (!pll_done) lowseen_q <= 1'b1;
               if (step_ok) begin
                  if (tally_last) begin
                     st_q <= ST_IDLE; sel_q <= '0; dir_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     st_q <= ST_SETUP;
                  end
               end else if (tmo_hit) begin
                  st_q <= ST_IDLE; sel_q <= '0; dir_q <= 1'b0;
                  err_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sel_code = sel_q;
   assign dir_up   = dir_q;
   assign step_en  = en_q;
   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;

   // Run-length of step_en, kept only for the pulse-width property.
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n || !step_en) run_q <= '0;
      else if (run_q != '1)   run_q <= run_q + RUN_W'(1);
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!step_en && !busy && !done && !err && sel_code == '0 && !dir_up));
   a_r2_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(sel_code) && $stable(dir_up)));
   a_r3_no_rsvd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> (sel_code != SEL_RSVD));
   a_r4_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |-> (run_q < RUN_W'(PULSE_CYC)));
   a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(step_en) && !err) |-> (run_q == RUN_W'(PULSE_CYC)));
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
   a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err, busy}));
   a_r10_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !step_en);
endmodule

// File: tb/sim_phstep_seq.sv
module sim_phstep_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 8;
   localparam int TMO_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [2:0]       req_target = '0;
   logic             req_up = 1'b0;
   logic [CNT_W-1:0] req_steps = '0;
   logic [TMO_W-1:0] tmo_limit = 16'd40;
   logic             pll_done = 1'b1;
   logic [2:0]       sel_code;
   logic             dir_up, step_en, busy, done, err;

   int checks = 0;
   int fails  = 0;

   // Behavioural PLL handshake stand-in.
   logic mdl_on = 1'b1;
   logic mdl_act = 1'b0;
   int   mdl_lat = 2;
   int   mdl_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phstep_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
      .req_up(req_up), .req_steps(req_steps), .tmo_limit(tmo_limit),
      .pll_done(pll_done), .sel_code(sel_code), .dir_up(dir_up),
      .step_en(step_en), .busy(busy), .done(done), .err(err));

   always @(posedge clk) begin
      if (mdl_act) begin
         if (mdl_cnt == 0) begin pll_done <= 1'b1; mdl_act <= 1'b0; end
         else mdl_cnt <= mdl_cnt - 1;
      end else if (step_en && mdl_on) begin
         mdl_act  <= 1'b1;
         pll_done <= 1'b0;
         mdl_cnt  <= mdl_lat;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic request(input logic [2:0] tgt, input logic up, input int n);
      @(negedge clk);
      req_valid = 1'b1; req_target = tgt; req_up = up; req_steps = CNT_W'(n);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(step_en == 0, "R1 step_en", int'(step_en), 0);
      chk(sel_code == 0, "R1 sel_code", int'(sel_code), 0);
      chk(dir_up == 0, "R1 dir_up", int'(dir_up), 0);
      chk(busy == 0, "R1 busy", int'(busy), 0);
      chk(done == 0 && err == 0, "R1 done/err", int'({done, err}), 0);
   endtask

   task automatic t_seq(input logic [2:0] tgt, input logic up, input int n,
                        input int lat, input bit poke);
      int pulses = 0, width = 0, ndone = 0;
      logic prev_en = 1'b0;
      logic [2:0] prev_sel;
      mdl_lat = lat;
      request(tgt, up, n);
      chk(busy == 1, "R10 busy after accept", int'(busy), 1);
      prev_sel = sel_code;
      for (int i = 0; i < 4000 && ndone == 0 && !err; i++) begin
         if (poke && i == 3) begin
            req_valid = 1'b1; req_target = ~tgt & 3'b110; req_up = ~up; req_steps = 8'd1;
         end else if (poke && i == 4) begin
            req_valid = 1'b0;
         end
         if (step_en && !prev_en) begin
            pulses++;
            chk(prev_sel == tgt, "R2 sel before rise", int'(prev_sel), int'(tgt));
            chk(!mdl_act, "R5 handshake complete before pulse", int'(mdl_act), 0);
         end
         if (step_en) begin
            width++;
            chk(sel_code == tgt && dir_up == up, poke ? "R9 sel/dir held" : "R2 sel/dir",
                int'({sel_code, dir_up}), int'({tgt, up}));
         end else if (prev_en) begin
            chk(width == 2, "R4 pulse width", width, 2);
            width = 0;
         end
         if (done) begin
            ndone++;
            chk(busy == 0, "R10 busy low with done", int'(busy), 0);
         end
         prev_en = step_en;
         prev_sel = sel_code;
         if (ndone == 0) @(negedge clk);
      end
      chk(pulses == n, poke ? "R9 pulse count kept" : "R6 pulse count", pulses, n);
      chk(ndone == 1 && err == 0, "R6 done seen", ndone, 1);
      @(negedge clk);
      chk(done == 0 && busy == 0, "R6 done single cycle", int'({done, busy}), 0);
   endtask

   task automatic t_zero();
      request(3'b011, 1'b1, 0);
      chk(done == 1 && busy == 0 && step_en == 0, "R7 zero count", int'({done, busy, step_en}), 4);
      @(negedge clk);
      chk(done == 0 && step_en == 0, "R7 done single", int'({done, step_en}), 0);
   endtask

   task automatic t_rsvd();
      int seen = 0;
      request(3'b111, 1'b1, 3);
      chk(err == 1 && busy == 0, "R3 reserved err", int'({err, busy}), 2);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (step_en || busy) seen++;
      end
      chk(seen == 0, "R3 no pulse", seen, 0);
   endtask

   task automatic t_timeout(input int lim);
      int n = -1;
      tmo_limit = TMO_W'(lim);
      mdl_on = 1'b0;
      request(3'b100, 1'b0, 2);
      for (int i = 0; i < 200 && n < 0; i++) begin
         if (step_en) n = 0;
         else @(negedge clk);
      end
      for (int i = 0; i < 200 && !err; i++) begin
         @(negedge clk);
         n++;
      end
      chk(n == lim + 1, "R8 timeout latency", n, lim + 1);
      chk(step_en == 0 && busy == 0 && sel_code == 0 && dir_up == 0,
          "R8 outputs quiet", int'({step_en, busy, sel_code, dir_up}), 0);
      mdl_on = 1'b1;
      tmo_limit = 16'd40;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_seq(3'b010, 1'b1, 3, 0, 1'b0);
      t_seq(3'b001, 1'b0, 2, 3, 1'b0);
      t_seq(3'b000, 1'b1, 4, 7, 1'b0);
      t_seq(3'b110, 1'b0, 1, 1, 1'b0);
      t_seq(3'b101, 1'b1, 5, 2, 1'b1);
      t_zero();
      t_rsvd();
      t_timeout(10);
      t_seq(3'b011, 1'b1, 2, 2, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule